// File: doc/BRIEF.md
# Four-Bit-Coded Integer ALU

This block is the integer arithmetic logic unit of a simple processor datapath. It takes two operands and a 4-bit operation select. It returns a result word and three status flags: Zero, Overflow and Carry. The nine defined operations are four bitwise functions, add, subtract, signed set-less-than, and left and right logical shifts.

One adder serves add, subtract and the signed comparison. Subtraction adds the inverted second operand with a carry-in of one. The flags come from that same adder. A branch-if-equal can subtract its two registers and test Zero.

The block is combinational by default. The parameter `REG_OUT` adds one output register stage, which can be used to close timing. Turning instruction bits into the select code is done elsewhere.

Top module: `int_alu`

## Requirements
- R1: Select 4'b0000 returns A AND B, 4'b0001 returns A OR B, 4'b1000 returns A XOR B and 4'b1100 returns NOT (A OR B), bit by bit.
- R2: Select 4'b0010 returns A + B modulo 2^WIDTH. Carry is the carry out of the top bit of that sum.
- R3: Select 4'b0110 returns A - B, formed as A + ~B + 1. Carry is the carry out of that sum, so it is 1 exactly when A >= B read as unsigned numbers.
- R4: Overflow is 1 only for ADD and SUB, and only when the true signed two's-complement result does not fit in WIDTH bits. For every other select it is 0.
- R5: Carry is 0 for every select other than ADD and SUB.
- R6: Select 4'b0111 returns 1 in bit 0 when A < B as signed two's-complement numbers, and 0 otherwise. All higher bits are 0.
- R7: Select 4'b1001 shifts A left by the amount in B[4:0] and fills with zeros. The other bits of B have no effect.
- R8: Select 4'b1010 shifts A right by the amount in B[4:0] and fills with zeros. The other bits of B have no effect.
- R9: For every defined select, Zero is 1 exactly when the result is all zeros. SUB of two equal operands therefore gives Zero = 1.
- R10: Any select code not listed in R1 to R8 gives a result of zero, and Zero, Overflow and Carry are all 0.
- R11: With REG_OUT = 1, the outputs show the inputs of the previous rising clock edge. A synchronous active-high reset clears the result and all three flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; used only for the optional output stage |
| rst | input | 1 | Synchronous active-high reset of the output stage |
| op_sel | input | 4 | Operation select code |
| opa | input | WIDTH | First operand A |
| opb | input | WIDTH | Second operand B; its low bits are the shift amount |
| result | output | WIDTH | Operation result |
| zero | output | 1 | Result-is-zero flag |
| overflow | output | 1 | Signed overflow flag for ADD and SUB |
| carry | output | 1 | Adder carry out for ADD and SUB |

## Verification
Directed cases target the adder edges:
- all ones plus one, which separates carry from signed overflow;
- the most positive value plus one, and the most negative value minus one, which give overflow without carry and with carry;
- equal-operand subtraction, which gives Zero together with Carry.

Comparison pairs that straddle the sign boundary show whether SLT uses the signed rule (sign XOR overflow) or a plain unsigned or sign-bit test. Shift amounts with bits set above bit 4 show whether only the low five bits are used. Unused codes show that nothing leaks through the result mux. A constrained random mix of all codes, with both full-range and small operands, then checks the combinational instance and the registered instance side by side.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [3:0] {
        OP_AND = 4'b0000,
        OP_OR  = 4'b0001,
        OP_ADD = 4'b0010,
        OP_SUB = 4'b0110,
        OP_SLT = 4'b0111,
        OP_XOR = 4'b1000,
        OP_SLL = 4'b1001,
        OP_SRL = 4'b1010,
        OP_NOR = 4'b1100
    } alu_op_e;

    typedef enum logic [2:0] {
        GRP_NONE,
        GRP_LOGIC,
        GRP_ARITH,
        GRP_CMP,
        GRP_SHIFT
    } res_grp_e;

    typedef enum logic [1:0] {
        LF_AND,
        LF_OR,
        LF_XOR,
        LF_NOR
    } logic_fn_e;

    typedef struct packed {
        res_grp_e  grp;
        logic_fn_e lfn;
        logic      subtract;
        logic      shift_left;
    } alu_ctrl_t;

    typedef struct packed {
        logic zero;
        logic ovf;
        logic cout;
    } alu_flags_t;

    function automatic alu_ctrl_t decode_op(logic [3:0] code);
        alu_ctrl_t c;
        c = '{grp: GRP_NONE, lfn: LF_AND, subtract: 1'b0, shift_left: 1'b0};
        case (code)
            OP_AND: begin c.grp = GRP_LOGIC; c.lfn = LF_AND; end
            OP_OR:  begin c.grp = GRP_LOGIC; c.lfn = LF_OR;  end
            OP_XOR: begin c.grp = GRP_LOGIC; c.lfn = LF_XOR; end
            OP_NOR: begin c.grp = GRP_LOGIC; c.lfn = LF_NOR; end
            OP_ADD: begin c.grp = GRP_ARITH; end
            OP_SUB: begin c.grp = GRP_ARITH; c.subtract = 1'b1; end
            OP_SLT: begin c.grp = GRP_CMP;   c.subtract = 1'b1; end
            OP_SLL: begin c.grp = GRP_SHIFT; c.shift_left = 1'b1; end
            OP_SRL: begin c.grp = GRP_SHIFT; end
            default: c.grp = GRP_NONE;
        endcase
        return c;
    endfunction

    function automatic logic code_is_defined(logic [3:0] code);
        return decode_op(code).grp != GRP_NONE;
    endfunction

endpackage

// File: rtl/alu_adder.sv
module alu_adder #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             subtract,
    output logic [WIDTH-1:0] sum,
    output logic             cout,
    output logic             ovf
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] b_eff;
    logic [WIDTH:0]   full;

    // Subtract reuses the adder: invert the second operand and carry in one.
    assign b_eff = subtract ? ~b : b;
    assign full  = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, subtract};
    assign sum   = full[WIDTH-1:0];
    assign cout  = full[WIDTH];
    // Same-signed inputs to the adder producing a different-signed sum.
    assign ovf   = (a[MSB] == b_eff[MSB]) && (full[MSB] != a[MSB]);

endmodule

// File: rtl/alu_logic.sv
module alu_logic
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic_fn_e        fn,
    output logic [WIDTH-1:0] y
);
    always_comb begin
        case (fn)
            LF_AND:  y = a & b;
            LF_OR:   y = a | b;
            LF_XOR:  y = a ^ b;
            LF_NOR:  y = ~(a | b);
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
    parameter int WIDTH = 32,
    parameter int SH_W  = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] value,
    input  logic [SH_W-1:0]  amount,
    input  logic             left,
    output logic [WIDTH-1:0] y
);
    logic [WIDTH-1:0]           rev_in;
    logic [WIDTH-1:0]           rev_out;
    logic [SH_W:0][WIDTH-1:0]   stage;

    // A left shift is a right shift of the bit-reversed word, reversed back.
    for (genvar k = 0; k < WIDTH; k++) begin : g_rev
        assign rev_in[k]  = value[WIDTH-1-k];
        assign rev_out[k] = stage[SH_W][WIDTH-1-k];
    end

    assign stage[0] = left ? rev_in : value;

    for (genvar i = 0; i < SH_W; i++) begin : g_stage
        assign stage[i+1] = amount[i] ? (stage[i] >> (2**i)) : stage[i];
    end

    assign y = left ? rev_out : stage[SH_W];

endmodule

// File: rtl/int_alu.sv
module int_alu
    import alu_pkg::*;
#(
    parameter int WIDTH   = 32,
    parameter bit REG_OUT = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [3:0]       op_sel,
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    output logic [WIDTH-1:0] result,
    output logic             zero,
    output logic             overflow,
    output logic             carry
);
    localparam int SH_W = $clog2(WIDTH);

    alu_ctrl_t        ctrl;
    logic [WIDTH-1:0] sum;
    logic             add_cout;
    logic             add_ovf;
    logic [WIDTH-1:0] logic_y;
    logic [WIDTH-1:0] shift_y;
    logic             less;
    logic [WIDTH-1:0] res_c;
    alu_flags_t       flg_c;

    assign ctrl = decode_op(op_sel);

    alu_adder #(.WIDTH(WIDTH)) u_add (
        .a        (opa),
        .b        (opb),
        .subtract (ctrl.subtract),
        .sum      (sum),
        .cout     (add_cout),
        .ovf      (add_ovf)
    );

    alu_logic #(.WIDTH(WIDTH)) u_logic (
        .a  (opa),
        .b  (opb),
        .fn (ctrl.lfn),
        .y  (logic_y)
    );

    alu_shifter #(.WIDTH(WIDTH), .SH_W(SH_W)) u_shift (
        .value  (opa),
        .amount (opb[SH_W-1:0]),
        .left   (ctrl.shift_left),
        .y      (shift_y)
    );

    // Signed less-than: sign of the difference corrected by overflow.
    assign less = sum[WIDTH-1] ^ add_ovf;

    always_comb begin
        case (ctrl.grp)
            GRP_LOGIC: res_c = logic_y;
            GRP_ARITH: res_c = sum;
            GRP_CMP:   res_c = {{(WIDTH-1){1'b0}}, less};
            GRP_SHIFT: res_c = shift_y;
            default:   res_c = '0;
        endcase
        flg_c.zero = (ctrl.grp != GRP_NONE) && (res_c == '0);
        flg_c.ovf  = (ctrl.grp == GRP_ARITH) && add_ovf;
        flg_c.cout = (ctrl.grp == GRP_ARITH) && add_cout;
    end

    if (REG_OUT) begin : g_reg
        logic [WIDTH-1:0] res_q;
        alu_flags_t       flg_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                res_q <= '0;
                flg_q <= '0;
            end else begin
                res_q <= res_c;
                flg_q <= flg_c;
            end
        end
        assign result   = res_q;
        assign zero     = flg_q.zero;
        assign overflow = flg_q.ovf;
        assign carry    = flg_q.cout;
    end else begin : g_comb
        assign result   = res_c;
        assign zero     = flg_c.zero;
        assign overflow = flg_c.ovf;
        assign carry    = flg_c.cout;
    end

endmodule

// File: rtl/int_alu_checker.sv
module int_alu_checker
    import alu_pkg::*;
#(
    parameter int WIDTH   = 32,
    parameter bit REG_OUT = 1'b0
) (
    input logic             clk,
    input logic             rst,
    input logic [3:0]       op_sel,
    input logic [WIDTH-1:0] opa,
    input logic [WIDTH-1:0] opb,
    input logic [WIDTH-1:0] result,
    input logic             zero,
    input logic             overflow,
    input logic             carry
);
    logic [3:0]       op_q;
    logic [WIDTH-1:0] a_q;
    logic [WIDTH-1:0] b_q;
    logic             live_q;
    logic [3:0]       seen_op;
    logic [WIDTH-1:0] seen_a;
    logic [WIDTH-1:0] seen_b;
    logic             live;
    logic             arith;

    // Track the inputs that the outputs currently stand for.
    always_ff @(posedge clk) begin
        if (rst) begin
            op_q   <= 4'b0000;
            a_q    <= '0;
            b_q    <= '0;
            live_q <= 1'b0;
        end else begin
            op_q   <= op_sel;
            a_q    <= opa;
            b_q    <= opb;
            live_q <= 1'b1;
        end
    end

    assign seen_op = REG_OUT ? op_q : op_sel;
    assign seen_a  = REG_OUT ? a_q  : opa;
    assign seen_b  = REG_OUT ? b_q  : opb;
    assign live    = !REG_OUT || live_q;
    assign arith   = (seen_op == OP_ADD) || (seen_op == OP_SUB);

    // R9
    a_r9_zero_matches: assert property (@(posedge clk) disable iff (rst)
        live && code_is_defined(seen_op) |-> zero == (result == '0));

    // R9
    a_r9_sub_equal: assert property (@(posedge clk) disable iff (rst)
        live && seen_op == OP_SUB && seen_a == seen_b |-> zero && carry);

    // R10
    a_r10_unused_quiet: assert property (@(posedge clk) disable iff (rst)
        live && !code_is_defined(seen_op)
        |-> result == '0 && !zero && !overflow && !carry);

    // R4
    a_r4_no_overflow: assert property (@(posedge clk) disable iff (rst)
        live && !arith |-> !overflow);

    // R5
    a_r5_no_carry: assert property (@(posedge clk) disable iff (rst)
        live && !arith |-> !carry);

    // R6
    a_r6_slt_shape: assert property (@(posedge clk) disable iff (rst)
        live && seen_op == OP_SLT |-> result[WIDTH-1:1] == '0);

    // R11
    a_r11_reset_clear: assert property (@(posedge clk)
        REG_OUT && rst |=> result == '0 && !zero && !overflow && !carry);

endmodule

bind int_alu int_alu_checker #(.WIDTH(WIDTH), .REG_OUT(REG_OUT)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .op_sel   (op_sel),
    .opa      (opa),
    .opb      (opb),
    .result   (result),
    .zero     (zero),
    .overflow (overflow),
    .carry    (carry)
);

// File: tb/int_alu_test.sv
module int_alu_test;
    localparam int CLK_PERIOD = 10;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [3:0]   op_sel = 4'b0000;
    logic [W-1:0] opa = '0;
    logic [W-1:0] opb = '0;

    logic [W-1:0] res_c, res_r;
    logic         z_c, v_c, c_c, z_r, v_r, c_r;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    logic [W+2:0] prev_exp;
    logic [3:0]   prev_op;
    bit           prev_valid = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    int_alu #(.WIDTH(W), .REG_OUT(1'b0)) uut (
        .clk(clk), .rst(rst), .op_sel(op_sel), .opa(opa), .opb(opb),
        .result(res_c), .zero(z_c), .overflow(v_c), .carry(c_c)
    );

    int_alu #(.WIDTH(W), .REG_OUT(1'b1)) uut_reg (
        .clk(clk), .rst(rst), .op_sel(op_sel), .opa(opa), .opb(opb),
        .result(res_r), .zero(z_r), .overflow(v_r), .carry(c_r)
    );

    // Model: {result, zero, overflow, carry}
    function automatic logic [W+2:0] model(logic [3:0] op, logic [W-1:0] a, logic [W-1:0] b);
        logic [W-1:0] r;
        logic [W:0]   s;
        logic         v, c, z, def;
        r = '0; v = 1'b0; c = 1'b0; def = 1'b1;
        case (op)
            4'b0000: r = a & b;
            4'b0001: r = a | b;
            4'b1000: r = a ^ b;
            4'b1100: r = ~(a | b);
            4'b0010: begin
                s = {1'b0, a} + {1'b0, b};
                r = s[W-1:0]; c = s[W];
                v = (a[W-1] == b[W-1]) && (r[W-1] != a[W-1]);
            end
            4'b0110: begin
                s = {1'b0, a} + {1'b0, ~b} + 1;
                r = s[W-1:0]; c = s[W];
                v = (a[W-1] != b[W-1]) && (r[W-1] != a[W-1]);
            end
            4'b0111: r = ($signed(a) < $signed(b)) ? 1 : 0;
            4'b1001: r = a << b[4:0];
            4'b1010: r = a >> b[4:0];
            default: def = 1'b0;
        endcase
        z = def && (r == '0);
        return {r, z, v, c};
    endfunction

    function automatic string res_tag(logic [3:0] op);
        case (op)
            4'b0000, 4'b0001, 4'b1000, 4'b1100: return "R1";
            4'b0010: return "R2";
            4'b0110: return "R3";
            4'b0111: return "R6";
            4'b1001: return "R7";
            4'b1010: return "R8";
            default: return "R10";
        endcase
    endfunction

    function automatic string carry_tag(logic [3:0] op);
        if (op == 4'b0010) return "R2";
        if (op == 4'b0110) return "R3";
        return "R5";
    endfunction

    function automatic string zero_tag(logic [3:0] op);
        if (res_tag(op) == "R10") return "R10";
        return "R9";
    endfunction

    task automatic check(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(string pfx, logic [3:0] op, logic [W+2:0] exp,
                             logic [W-1:0] r, logic z, logic v, logic c);
        string vt;
        vt = (op == 4'b0010 || op == 4'b0110) ? "R4" : "R4";
        check(pfx == "" ? res_tag(op) : pfx, "result", r, exp[W+2:3]);
        check(pfx == "" ? zero_tag(op) : pfx, "zero", {31'd0, z}, {31'd0, exp[2]});
        check(pfx == "" ? vt : pfx, "overflow", {31'd0, v}, {31'd0, exp[1]});
        check(pfx == "" ? carry_tag(op) : pfx, "carry", {31'd0, c}, {31'd0, exp[0]});
    endtask

    // Drive at the falling edge; the combinational copy is checked right
    // after, the registered copy (R11) one cycle later, before the next drive.
    task automatic apply(logic [3:0] op, logic [W-1:0] a, logic [W-1:0] b);
        logic [W+2:0] e;
        @(negedge clk);
        if (prev_valid) check_all("R11", prev_op, prev_exp, res_r, z_r, v_r, c_r);
        op_sel = op; opa = a; opb = b;
        #1;
        e = model(op, a, b);
        check_all("", op, e, res_c, z_c, v_c, c_c);
        prev_exp = e; prev_op = op; prev_valid = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        logic [3:0] codes [12];
        codes = '{4'b0000, 4'b0001, 4'b0010, 4'b0110, 4'b0111, 4'b1100,
                  4'b1000, 4'b1001, 4'b1010, 4'b0011, 4'b0100, 4'b1111};
        void'($urandom(32'd20240611));

        repeat (3) @(posedge clk);
        @(negedge clk);
        // Reset state: registered copy cleared (R11); combinational AND of zeros (R9)
        check("R11", "reset result", res_r, '0);
        check("R11", "reset flags", {29'd0, z_r, v_r, c_r}, '0);
        check("R9", "reset-time zero flag", {31'd0, z_c}, 32'd1);
        rst = 1'b0;

        // R1 bitwise
        apply(4'b0000, 32'hF0F0_1234, 32'h0FF0_FF00);
        apply(4'b0001, 32'hF0F0_1234, 32'h0FF0_FF00);
        apply(4'b1000, 32'hF0F0_1234, 32'h0FF0_FF00);
        apply(4'b1100, 32'hF0F0_1234, 32'h0FF0_FF00);
        apply(4'b1100, 32'hFFFF_FFFF, 32'h0);
        // R2 carry without overflow, overflow without carry
        apply(4'b0010, 32'hFFFF_FFFF, 32'h1);
        apply(4'b0010, 32'h7FFF_FFFF, 32'h1);
        apply(4'b0010, 32'h8000_0000, 32'h8000_0000);
        // R3 / R9 equal operands, borrow, overflow
        apply(4'b0110, 32'd42, 32'd42);
        apply(4'b0110, 32'd42, 32'd43);
        apply(4'b0110, 32'h8000_0000, 32'h1);
        apply(4'b0110, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
        // R6 signed compare across the sign boundary
        apply(4'b0111, 32'h8000_0000, 32'h1);
        apply(4'b0111, 32'h7FFF_FFFF, 32'h8000_0000);
        apply(4'b0111, 32'hFFFF_FFFF, 32'h0);
        apply(4'b0111, 32'd5, 32'd5);
        // R7 / R8 shift amount from low five bits only
        apply(4'b1001, 32'h8000_0001, 32'hFFFF_FFE3);
        apply(4'b1001, 32'h0000_0001, 32'd31);
        apply(4'b1010, 32'h8000_0000, 32'h0000_0120);
        apply(4'b1010, 32'h8000_0000, 32'd31);
        apply(4'b1010, 32'h1234_5678, 32'h0);
        // R10 unused codes
        apply(4'b0011, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        apply(4'b1111, 32'h0, 32'h0);
        apply(4'b0101, 32'h7FFF_FFFF, 32'h1);

        for (int i = 0; i < 600; i++) begin
            logic [W-1:0] a, b;
            logic [3:0]   op;
            op = codes[$urandom_range(0, 11)];
            a  = $urandom();
            b  = $urandom();
            case ($urandom_range(0, 3))
                0: begin a = a & 32'hF; b = b & 32'hF; end
                1: b = a;
                default: ;
            endcase
            apply(op, a, b);
        end

        @(negedge clk);
        check_all("R11", prev_op, prev_exp, res_r, z_r, v_r, c_r);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule